// File: doc/BRIEF.md
# Running-Sum Filtered Serial Receiver

This block receives asynchronous serial frames over a noisy line without a baud-rate timer. The raw line is sampled on every system clock. A recursive running sum counts how many of the most recent M samples were high, and at the close of every M-clock window a magnitude comparator turns that count into one cleaned window bit. Ten window bits make one bit time, so the programmed window length alone sets the baud rate: M is one tenth of the wanted bit period in clocks.

A frame decoder works on the stream of window bits. It leaves idle on the first low window bit. It then votes over ten window bits to confirm the start bit, to decide each of eight data bits, received least significant bit first, and to decide the stop bit. A good frame yields a one-clock valid strobe with the byte. A bad stop bit yields a one-clock framing-error pulse instead. The window length may be reprogrammed at any time, but the change waits until the decoder is idle.

Top module: `rrs_uart_rx`

## Requirements
- R1: At the end of each window, the window bit is 1 only if more than half of that window's M line samples were high. A window with exactly M/2 high samples gives 0.
- R2: The window length is taken from `win_len`. A value of 0 acts as 1, and values above MAX_WIN (256) act as 256. One bit time is 10*M clocks, and no other timer exists.
- R3: In idle, the first low window bit starts a frame. The start bit is accepted only if fewer than 5 of its 10 window bits are high. Otherwise the decoder returns to idle and produces no strobe of either kind.
- R4: A data bit is 1 only if at least 6 of its 10 window bits are high. Eight data bits follow the start bit, and the first received bit lands in `rx_data[0]`.
- R5: A stop bit with at least 6 of 10 high window bits raises `rx_valid` for exactly one clock, with the byte on `rx_data`. `rx_data` then holds until the next valid strobe.
- R6: A stop bit with 5 or fewer high window bits raises `rx_frame_err` for one clock and leaves `rx_data` unchanged. The decoder then returns to idle.
- R7: `rx_valid` and `rx_frame_err` are never high in the same clock.
- R8: A new `win_len` is applied only while the decoder is idle. A frame already in progress is decoded at the old length. When a new length is applied, the filter is refilled as an idle-high line.
- R9: Reset clears the running sum and the delay line and drives `rx_data`, `rx_valid` and `rx_frame_err` to zero.
- R10: Single-clock glitches spaced at least M clocks apart do not change the decoded byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; the line is sampled on every rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rx_line | input | 1 | Raw serial line, idle high |
| win_len | input | 9 | Window length M in clocks (bit time = 10*M) |
| rx_data | output | 8 | Last correctly framed byte |
| rx_valid | output | 1 | One-clock strobe for a good frame |
| rx_frame_err | output | 1 | One-clock strobe for a frame with a bad stop bit |

## Verification
The risky coincidence is a window-length change that arrives while the stop bit is being decided. The decoder's return to idle and the refill of the filter are then only one clock apart. The bench provokes this by changing `win_len` in the middle of a frame. It expects that frame to decode at the old rate, and the next frame, sent at the new rate after an idle gap, to decode correctly. A framing error followed at once by a good frame tests in the same way that the error path hands back to idle and leaves `rx_data` untouched.

// File: rtl/rrs_pkg.sv
package rrs_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_START = 2'd1,
      ST_DATA  = 2'd2,
      ST_STOP  = 2'd3
   } rx_state_e;

endpackage

// File: rtl/rrs_line_sync.sv
module rrs_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic d_i,
   output logic q_o
);

   if (STAGES < 0 || STAGES > 4) begin : g_bad_stages
      $error("rrs_line_sync: STAGES must be 0..4");
   end

   if (STAGES == 0) begin : g_direct
      assign q_o = d_i;
   end else begin : g_flops
      logic [STAGES-1:0] pipe_q;
      always_ff @(posedge clk) begin
         if (rst) pipe_q <= '1;
         else     pipe_q <= (pipe_q << 1) | STAGES'(d_i);
      end
      assign q_o = pipe_q[STAGES-1];
   end

endmodule

// File: rtl/rrs_window_filter.sv
module rrs_window_filter #(
   parameter int MAX_WIN = 256,
   parameter int LEN_W   = $clog2(MAX_WIN + 1)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             sample_i,
   input  logic [LEN_W-1:0] win_len_i,
   input  logic             idle_i,
   output logic             tick_o,
   output logic             bit_o
);

   localparam int IW = $clog2(MAX_WIN);
   localparam int SW = LEN_W + 1;

   if (MAX_WIN < 2) begin : g_bad_win
      $error("rrs_window_filter: MAX_WIN must be at least 2");
   end
   if (LEN_W < $clog2(MAX_WIN + 1)) begin : g_bad_len
      $error("rrs_window_filter: LEN_W too narrow for MAX_WIN");
   end

   logic [LEN_W-1:0]   m_req, m_q, cnt_q;
   logic [MAX_WIN-1:0] dly_q;
   logic [SW-1:0]      sum_q, sum_nx;
   logic [IW-1:0]      tap_idx;
   logic               tap, win_end, flush;

   always_comb begin
      if (win_len_i == '0)                    m_req = LEN_W'(1);
      else if (win_len_i > LEN_W'(MAX_WIN))   m_req = LEN_W'(MAX_WIN);
      else                                    m_req = win_len_i;
      tap_idx = IW'(m_q - 1'b1);
      tap     = dly_q[tap_idx];
      sum_nx  = sum_q + SW'(sample_i) - SW'(tap);
      win_end = (cnt_q == m_q - 1'b1);
      flush   = idle_i && (m_req != m_q);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         m_q    <= LEN_W'(1);
         cnt_q  <= '0;
         dly_q  <= '0;
         sum_q  <= '0;
         tick_o <= 1'b0;
         bit_o  <= 1'b1;
      end else if (flush) begin
         m_q    <= m_req;
         cnt_q  <= '0;
         dly_q  <= '1;
         sum_q  <= SW'(m_req);
         tick_o <= 1'b0;
         bit_o  <= 1'b1;
      end else begin
         dly_q  <= {dly_q[MAX_WIN-2:0], sample_i};
         sum_q  <= sum_nx;
         cnt_q  <= win_end ? '0 : cnt_q + 1'b1;
         tick_o <= win_end;
         if (win_end) bit_o <= (sum_nx > SW'(m_q >> 1));
      end
   end

   // R8
   len_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !idle_i |=> $stable(m_q));

   // R2
   len_range_chk: assert property (@(posedge clk) disable iff (rst)
      (m_q != '0) && (m_q <= LEN_W'(MAX_WIN)));

   // R9
   sum_bound_chk: assert property (@(posedge clk) disable iff (rst)
      sum_q <= SW'(m_q));

   // R2
   tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
      (tick_o && m_q != LEN_W'(1)) |=> !tick_o);

endmodule

// File: rtl/rrs_frame_fsm.sv
module rrs_frame_fsm
   import rrs_pkg::*;
#(
   parameter int VOTES  = 10,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              tick_i,
   input  logic              bit_i,
   output logic              idle_o,
   output logic [DATA_W-1:0] data_o,
   output logic              valid_o,
   output logic              ferr_o
);

   localparam int VW = $clog2(VOTES);
   localparam int OW = $clog2(VOTES + 1);
   localparam int BW = $clog2(DATA_W);

   if (VOTES < 3) begin : g_bad_votes
      $error("rrs_frame_fsm: VOTES must be at least 3");
   end
   if (DATA_W < 2) begin : g_bad_width
      $error("rrs_frame_fsm: DATA_W must be at least 2");
   end

   rx_state_e         st_q;
   logic [VW-1:0]     votes_q;
   logic [OW-1:0]     ones_q, ones_nx;
   logic [BW-1:0]     idx_q;
   logic [DATA_W-1:0] sh_q;
   logic              last_vote, vote_hi, vote_lo;

   always_comb begin
      ones_nx   = ones_q + OW'(bit_i);
      last_vote = (votes_q == VW'(VOTES - 1));
      vote_hi   = (32'(ones_nx) * 2) > 32'(VOTES);
      vote_lo   = (32'(ones_nx) * 2) < 32'(VOTES);
   end

   assign idle_o = (st_q == ST_IDLE);

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q    <= ST_IDLE;
         votes_q <= '0;
         ones_q  <= '0;
         idx_q   <= '0;
         sh_q    <= '0;
         data_o  <= '0;
         valid_o <= 1'b0;
         ferr_o  <= 1'b0;
      end else begin
         valid_o <= 1'b0;
         ferr_o  <= 1'b0;
         if (st_q == ST_IDLE) begin
            if (tick_i && !bit_i) begin
               st_q    <= ST_START;
               votes_q <= VW'(1);
               ones_q  <= '0;
            end
         end else if (tick_i) begin
            if (!last_vote) begin
               votes_q <= votes_q + 1'b1;
               ones_q  <= ones_nx;
            end else begin
               votes_q <= '0;
               ones_q  <= '0;
               case (st_q)
                  ST_START: begin
                     idx_q <= '0;
                     st_q  <= vote_lo ? ST_DATA : ST_IDLE;
                  end
                  ST_DATA: begin
                     sh_q <= {vote_hi, sh_q[DATA_W-1:1]};
                     if (idx_q == BW'(DATA_W - 1)) st_q <= ST_STOP;
                     else                          idx_q <= idx_q + 1'b1;
                  end
                  default: begin
                     if (vote_hi) begin
                        valid_o <= 1'b1;
                        data_o  <= sh_q;
                     end else begin
                        ferr_o  <= 1'b1;
                     end
                     st_q <= ST_IDLE;
                  end
               endcase
            end
         end
      end
   end

   // R7
   strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
      !(valid_o && ferr_o));

   // R5
   valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      valid_o |=> !valid_o);

   // R6
   ferr_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      ferr_o |=> !ferr_o);

   // R5
   data_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !$stable(data_o) |-> valid_o);

   // R6
   ferr_idle_chk: assert property (@(posedge clk) disable iff (rst)
      ferr_o |-> idle_o);

endmodule

// File: rtl/rrs_uart_rx.sv
module rrs_uart_rx #(
   parameter int MAX_WIN     = 256,
   parameter int LEN_W       = $clog2(MAX_WIN + 1),
   parameter int VOTES       = 10,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              rx_line,
   input  logic [LEN_W-1:0]  win_len,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_valid,
   output logic              rx_frame_err
);

   logic line_s, win_tick, win_bit, fsm_idle;

   rrs_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst (rst),
      .d_i (rx_line),
      .q_o (line_s)
   );

   rrs_window_filter #(.MAX_WIN(MAX_WIN), .LEN_W(LEN_W)) u_filter (
      .clk       (clk),
      .rst       (rst),
      .sample_i  (line_s),
      .win_len_i (win_len),
      .idle_i    (fsm_idle),
      .tick_o    (win_tick),
      .bit_o     (win_bit)
   );

   rrs_frame_fsm #(.VOTES(VOTES), .DATA_W(DATA_W)) u_fsm (
      .clk     (clk),
      .rst     (rst),
      .tick_i  (win_tick),
      .bit_i   (win_bit),
      .idle_o  (fsm_idle),
      .data_o  (rx_data),
      .valid_o (rx_valid),
      .ferr_o  (rx_frame_err)
   );

endmodule

// File: tb/rrs_uart_rx_tb.sv
module rrs_uart_rx_tb;

   typedef struct {
      logic [7:0] data;
      bit         is_err;
      string      req;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       rx_line = 1'b1;
   logic [8:0] win_len = 9'd4;
   logic [7:0] rx_data;
   logic       rx_valid, rx_frame_err;

   int   checks = 0;
   int   failures = 0;
   bit   done = 1'b0;
   exp_t exp_q[$];
   logic [7:0] last_good = 8'h00;
   bit   pulse_pending = 1'b0;

   always #2.5 clk = ~clk;

   rrs_uart_rx u_dut (
      .clk          (clk),
      .rst          (rst),
      .rx_line      (rx_line),
      .win_len      (win_len),
      .rx_data      (rx_data),
      .rx_valid     (rx_valid),
      .rx_frame_err (rx_frame_err)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   task automatic expect_ok(input logic [7:0] b, input string req);
      exp_t e;
      e.data = b; e.is_err = 1'b0; e.req = req;
      exp_q.push_back(e);
      last_good = b;
   endtask

   task automatic expect_err(input string req);
      exp_t e;
      e.data = last_good; e.is_err = 1'b1; e.req = req;
      exp_q.push_back(e);
   endtask

   // mode 0 clean, 1 glitch every 5 clocks, 2 alternating 1/0, 3 repeating 1110
   task automatic drive_bit(input logic v, input int m, input int mode);
      for (int i = 0; i < 10 * m; i++) begin
         @(negedge clk);
         case (mode)
            1:       rx_line = (i % 5 == 2) ? ~v : v;
            2:       rx_line = (i % 2 == 0);
            3:       rx_line = (i % 4 != 3);
            default: rx_line = v;
         endcase
      end
   endtask

   task automatic send_frame(input logic [7:0] b, input int m, input bit stop_hi,
                             input int mode, input int sp_idx, input int sp_mode,
                             input int new_len);
      drive_bit(1'b1, m, 0);
      drive_bit(1'b0, m, mode);
      for (int i = 0; i < 8; i++) begin
         if (i == 4 && new_len >= 0) win_len = 9'(new_len);
         drive_bit(b[i], m, (i == sp_idx) ? sp_mode : mode);
      end
      drive_bit(stop_hi, m, mode);
      for (int i = 0; i < 3; i++) drive_bit(1'b1, m, 0);
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (!rst) begin
         if (pulse_pending) begin
            check(!rx_valid && !rx_frame_err, "R5", "strobe longer than one clock",
                  {rx_valid, rx_frame_err}, 0);
            pulse_pending = 1'b0;
         end else if (rx_valid || rx_frame_err) begin
            pulse_pending = 1'b1;
            check(!(rx_valid && rx_frame_err), "R7", "valid and frame error together",
                  {rx_valid, rx_frame_err}, 0);
            if (exp_q.size() == 0) begin
               check(1'b0, "R3", "unexpected strobe", {rx_valid, rx_frame_err}, 0);
            end else begin
               exp_t e;
               e = exp_q.pop_front();
               check(rx_frame_err == e.is_err, e.req, "strobe kind (1=frame error)",
                     rx_frame_err, e.is_err);
               check(rx_data == e.data, e.req, "rx_data", rx_data, e.data);
            end
         end
      end
   end

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=0 expected=1");
         finish_run();
      end
   end

   initial begin
      repeat (10) @(negedge clk);
      // R9: reset state
      check(rx_data == 8'h00, "R9", "rx_data in reset", rx_data, 0);
      check(rx_valid == 1'b0, "R9", "rx_valid in reset", rx_valid, 0);
      check(rx_frame_err == 1'b0, "R9", "rx_frame_err in reset", rx_frame_err, 0);
      rst = 1'b0;
      repeat (5) @(negedge clk);
      check(rx_valid == 1'b0 && rx_frame_err == 1'b0, "R9", "strobes after reset",
            {rx_valid, rx_frame_err}, 0);

      // R4: clean frames, LSB first, M=4
      expect_ok(8'h55, "R4"); send_frame(8'h55, 4, 1'b1, 0, -1, 0, -1);
      expect_ok(8'hA3, "R4"); send_frame(8'hA3, 4, 1'b1, 0, -1, 0, -1);
      expect_ok(8'h00, "R4"); send_frame(8'h00, 4, 1'b1, 0, -1, 0, -1);
      expect_ok(8'hFF, "R5"); send_frame(8'hFF, 4, 1'b1, 0, -1, 0, -1);

      // R10: spaced single-clock glitches
      expect_ok(8'h3C, "R10"); send_frame(8'h3C, 4, 1'b1, 1, -1, 0, -1);
      win_len = 9'd8;
      expect_ok(8'hC5, "R10"); send_frame(8'hC5, 8, 1'b1, 1, -1, 0, -1);
      win_len = 9'd4;

      // R1: half-high windows give 0, three-quarter-high windows give 1
      expect_ok(8'hF7, "R1"); send_frame(8'hFF, 4, 1'b1, 0, 3, 2, -1);
      expect_ok(8'h20, "R1"); send_frame(8'h00, 4, 1'b1, 0, 5, 3, -1);

      // R3: short low pulse is rejected as a start bit, then a real frame
      drive_bit(1'b1, 4, 0);
      for (int i = 0; i < 8; i++) begin @(negedge clk); rx_line = 1'b0; end
      for (int i = 0; i < 3; i++) drive_bit(1'b1, 4, 0);
      check(exp_q.size() == 0, "R3", "pending items after false start", exp_q.size(), 0);
      expect_ok(8'h81, "R3"); send_frame(8'h81, 4, 1'b1, 0, -1, 0, -1);

      // R6: low stop bit, data held; then a good frame follows
      expect_err("R6"); send_frame(8'h6E, 4, 1'b0, 0, -1, 0, -1);
      expect_ok(8'h19, "R6"); send_frame(8'h19, 4, 1'b1, 0, -1, 0, -1);

      // R8: length change mid-frame waits for idle
      expect_ok(8'h4B, "R8"); send_frame(8'h4B, 4, 1'b1, 0, -1, 0, 8);
      expect_ok(8'hD2, "R8"); send_frame(8'hD2, 8, 1'b1, 0, -1, 0, -1);

      // R2: other lengths and clamping
      win_len = 9'd7;
      expect_ok(8'h96, "R2"); send_frame(8'h96, 7, 1'b1, 0, -1, 0, -1);
      win_len = 9'd0;
      expect_ok(8'h5A, "R2"); send_frame(8'h5A, 1, 1'b1, 0, -1, 0, -1);
      win_len = 9'd16;
      expect_ok(8'h3F, "R2"); send_frame(8'h3F, 16, 1'b1, 0, -1, 0, -1);
      win_len = 9'd300;
      expect_ok(8'hE1, "R2"); send_frame(8'hE1, 256, 1'b1, 0, -1, 0, -1);

      repeat (20) @(negedge clk);
      check(exp_q.size() == 0, "R5", "frames never reported", exp_q.size(), 0);
      done = 1'b1;
      finish_run();
   end

endmodule